// File: doc/BRIEF.md
# Cascaded Two-Level DMA Request Arbiter

This block decides which DMA channel owns the bus when two four-channel request controllers are chained. The primary controller does not talk to the bus master. When any of its unmasked channels is pending, it raises a request on channel 0 of the secondary controller. That channel is reserved for the link and is called the cascade. Only the secondary controller drives hold request to the bus master.

When hold acknowledge arrives, the block first resolves priority inside the secondary controller. If the cascade wins, it then resolves priority among the primary controller's channels to find the channel that is really being served. It acknowledges that channel, and for a primary channel it also acknowledges the cascade.

Each channel has a pending bit. The bit follows the edges of the channel's request line and can also be set or cleared through a request-write port. A terminal-count input ends the current grant. Register programming and address generation live elsewhere.

The channel count per controller is a parameter and must be a power of two. Global channel index c maps to the primary controller for c < N and to the secondary controller for c >= N. Index N is the cascade.

Top module: `cascaded_dma_arbiter`

## Requirements
- R1: After reset, hrq_o, grant_valid_o and dack_o are 0 and grant_idx_o is 0.
- R2: A channel's pending bit is set at the clock edge where its request line is first seen high, and cleared at the edge where it is first seen low; a level held steady leaves the bit unchanged.
- R3: When sw_we_i is high, the pending bit of channel sw_ch_i is loaded with sw_set_i at that edge. This write takes precedence over a request edge on the same channel in the same cycle.
- R4: Within each controller, priority is fixed: the lowest channel number among pending channels whose mask_i bit is 0 wins, and a masked channel never wins.
- R5: The cascade request is a register. It is set one edge after the primary controller has an unmasked pending bit. It is cleared when the primary controller has no pending bit at all. Otherwise (pending but all masked) it keeps its value.
- R6: hrq_o is a register. It is set one edge after the secondary controller, with its channel 0 taken from the cascade request, has an unmasked pending bit. It is cleared when that controller has no pending bit. Otherwise it keeps its value. A primary request therefore reaches hrq_o two edges after its pending bit is set.
- R7: At each edge where hlda_i and hrq_o are both high, the grant is re-evaluated and loaded. grant_idx_o carries the global channel number. dack_o is one-hot on that channel, and dack_o[N] is also high for a primary grant. When the secondary winner is the cascade, the grant goes to the primary winner.
- R8: When no unmasked channel is found, including when the cascade wins but all pending primary channels are masked, grant_valid_o is 0 and dack_o is 0.
- R9: Channel N is reserved as the cascade. req_i[N] and request writes that target N have no effect, and grant_idx_o never shows N while grant_valid_o is high.
- R10: When tc_i is high while grant_valid_o is high, the next edge clears grant_valid_o, dack_o and hrq_o. For a primary grant it also clears the cascade request, so hrq_o returns at the earliest two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 2*N | Request lines; bit c is global channel c |
| mask_i | input | 2*N | Mask bits; 1 blocks a channel, bit N masks the cascade |
| sw_we_i | input | 1 | Request-write strobe |
| sw_ch_i | input | log2(2*N) | Channel targeted by the request write |
| sw_set_i | input | 1 | Value loaded into the targeted pending bit |
| hlda_i | input | 1 | Hold acknowledge from the bus master |
| tc_i | input | 1 | Terminal count of the granted transfer |
| hrq_o | output | 1 | Hold request to the bus master |
| grant_valid_o | output | 1 | A channel is granted this cycle |
| grant_idx_o | output | log2(2*N) | Global number of the granted channel |
| dack_o | output | 2*N | Channel acknowledges, bit N is the cascade acknowledge |

## Verification
The assertions assume that tc_i is only meaningful in a cycle that carries a grant. They also assume that hlda_i may arrive in any cycle, whether or not hrq_o is high. Under these assumptions, a grant must always be traceable to a cycle where both hold signals were high, and the cascade acknowledge may appear only with a primary grant.

The stimulus leaves every input free. It sweeps every request pattern against several mask patterns related to that pattern, then drives long runs of pseudo-random requests, masks, writes, hold acknowledges and terminal counts. A cycle model derived from the requirements predicts every output each cycle.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
package dma_arb_pkg;
  // update of a sticky request register
  typedef enum logic [1:0] {
    HOLD_KEEP = 2'd0,
    HOLD_SET  = 2'd1,
    HOLD_CLR  = 2'd2
  } hold_op_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dma_req_status.sv
`timescale 1ns/1ps
module dma_req_status
  import dma_arb_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter bit          RSV_CH0 = 1'b0,
  localparam int unsigned CW    = idx_width(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          sw_we_i,
  input  logic [CW-1:0] sw_ch_i,
  input  logic          sw_set_i,
  output logic [N-1:0]  pend_o
);
  logic [N-1:0] req_d_q;
  logic [N-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_d_q <= '0;
    else         req_d_q <= req_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_ch
    if (RSV_CH0 && g == 0) begin : g_rsv
      // cascade slot: no local status
      assign pend_q[g] = 1'b0;
    end else begin : g_bit
      logic pend_d;
      always_comb begin
        pend_d = pend_q[g];
        if (req_i[g] && !req_d_q[g])      pend_d = 1'b1;
        else if (!req_i[g] && req_d_q[g]) pend_d = 1'b0;
        if (sw_we_i && sw_ch_i == CW'(g)) pend_d = sw_set_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q[g] <= 1'b0;
        else         pend_q[g] <= pend_d;
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dma_prio_pick.sv
`timescale 1ns/1ps
module dma_prio_pick
  import dma_arb_pkg::*;
#(
  parameter int unsigned N  = 4,
  localparam int unsigned CW = idx_width(N)
) (
  input  logic [N-1:0]  vld_i,
  output logic          found_o,
  output logic [CW-1:0] idx_o
);
  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld_i[i]) begin
        found_o = 1'b1;
        idx_o   = CW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_hold_reg.sv
`timescale 1ns/1ps
module dma_hold_reg
  import dma_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_pend_i,
  input  logic any_live_i,
  input  logic kill_i,
  output logic q_o
);
  hold_op_e op;
  logic     q;

  always_comb begin
    if (kill_i || !any_pend_i) op = HOLD_CLR;
    else if (any_live_i)       op = HOLD_SET;
    else                       op = HOLD_KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else begin
      unique case (op)
        HOLD_SET: q <= 1'b1;
        HOLD_CLR: q <= 1'b0;
        default:  q <= q;
      endcase
    end
  end

  assign q_o = q;
endmodule

// File: rtl/cascaded_dma_arbiter.sv
`timescale 1ns/1ps
module cascaded_dma_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned N = 4,
  localparam int unsigned CW    = idx_width(N),
  localparam int unsigned IDX_W = CW + 1,
  localparam int unsigned TOT   = 2 * N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TOT-1:0]   req_i,
  input  logic [TOT-1:0]   mask_i,
  input  logic             sw_we_i,
  input  logic [IDX_W-1:0] sw_ch_i,
  input  logic             sw_set_i,
  input  logic             hlda_i,
  input  logic             tc_i,
  output logic             hrq_o,
  output logic             grant_valid_o,
  output logic [IDX_W-1:0] grant_idx_o,
  output logic [TOT-1:0]   dack_o
);
  logic [N-1:0]     pend_p, pend_s, sec_eff, live_p, live_s;
  logic             casc_q, hrq_q;
  logic             p_found, s_found, win_found;
  logic [CW-1:0]    p_idx, s_idx;
  logic [IDX_W-1:0] win_idx;
  logic             gv_q;
  logic [IDX_W-1:0] gi_q;
  logic             tc_kill, tc_kill_p;

  dma_req_status #(.N(N), .RSV_CH0(1'b0)) i_stat_p (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i[N-1:0]),
    .sw_we_i  (sw_we_i && !sw_ch_i[IDX_W-1]),
    .sw_ch_i  (sw_ch_i[CW-1:0]),
    .sw_set_i (sw_set_i),
    .pend_o   (pend_p)
  );

  dma_req_status #(.N(N), .RSV_CH0(1'b1)) i_stat_s (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i[TOT-1:N]),
    .sw_we_i  (sw_we_i && sw_ch_i[IDX_W-1]),
    .sw_ch_i  (sw_ch_i[CW-1:0]),
    .sw_set_i (sw_set_i),
    .pend_o   (pend_s)
  );

  // secondary channel 0 is fed by the cascade register
  assign sec_eff = {pend_s[N-1:1], casc_q};
  assign live_p  = pend_p  & ~mask_i[N-1:0];
  assign live_s  = sec_eff & ~mask_i[TOT-1:N];

  assign tc_kill   = tc_i && gv_q;
  assign tc_kill_p = tc_kill && !gi_q[IDX_W-1];

  dma_hold_reg i_casc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .any_pend_i (|pend_p),
    .any_live_i (|live_p),
    .kill_i     (tc_kill_p),
    .q_o        (casc_q)
  );

  dma_hold_reg i_hrq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .any_pend_i (|sec_eff),
    .any_live_i (|live_s),
    .kill_i     (tc_kill),
    .q_o        (hrq_q)
  );

  dma_prio_pick #(.N(N)) i_pick_p (
    .vld_i   (live_p),
    .found_o (p_found),
    .idx_o   (p_idx)
  );

  dma_prio_pick #(.N(N)) i_pick_s (
    .vld_i   (live_s),
    .found_o (s_found),
    .idx_o   (s_idx)
  );

  // second level: a cascade win descends into the primary controller
  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    if (s_found) begin
      if (s_idx == '0) begin
        win_found = p_found;
        win_idx   = {1'b0, p_idx};
      end else begin
        win_found = 1'b1;
        win_idx   = {1'b1, s_idx};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gv_q <= 1'b0;
      gi_q <= '0;
    end else if (tc_kill) begin
      gv_q <= 1'b0;
      gi_q <= '0;
    end else if (hlda_i && hrq_q && win_found) begin
      gv_q <= 1'b1;
      gi_q <= win_idx;
    end else begin
      gv_q <= 1'b0;
      gi_q <= '0;
    end
  end

  for (genvar g = 0; g < TOT; g++) begin : g_dack
    if (g == N) begin : g_casc
      assign dack_o[g] = gv_q && !gi_q[IDX_W-1];
    end else begin : g_chan
      assign dack_o[g] = gv_q && (gi_q == IDX_W'(g));
    end
  end

  assign hrq_o         = hrq_q;
  assign grant_valid_o = gv_q;
  assign grant_idx_o   = gi_q;

  // R7: at most one real channel acknowledged
  a_r7_single_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dack_o[TOT-1:N+1], dack_o[N-1:0]}));

  // R7: cascade acknowledge only with a primary grant
  a_r7_cascade_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o[N] |-> (grant_valid_o && !grant_idx_o[IDX_W-1]));

  // R7: a grant follows a cycle with both hold signals high
  a_r7_grant_after_hlda: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_valid_o) |-> $past(hlda_i && hrq_o));

  // R9: the cascade slot is never granted
  a_r9_no_cascade_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (grant_idx_o != IDX_W'(N)));

  // R10: terminal count ends the grant and the hold request
  a_r10_tc_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i && grant_valid_o) |=> (!grant_valid_o && !hrq_o && dack_o == '0));
endmodule

// File: tb/test_cascaded_dma_arbiter.sv
`timescale 1ns/1ps
module test_cascaded_dma_arbiter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] req, mask;
  logic       swe, sset, hlda, tc;
  logic [2:0] sch;
  logic       hrq_o, grant_valid_o;
  logic [2:0] grant_idx_o;
  logic [7:0] dack_o;
  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #10 clk_i = ~clk_i;

  cascaded_dma_arbiter #(.N(4)) i_cascaded_dma_arbiter (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .mask_i(mask),
    .sw_we_i(swe), .sw_ch_i(sch), .sw_set_i(sset), .hlda_i(hlda), .tc_i(tc),
    .hrq_o(hrq_o), .grant_valid_o(grant_valid_o), .grant_idx_o(grant_idx_o),
    .dack_o(dack_o)
  );

  // cycle model built from the requirements
  logic [7:0] m_pend, m_prev;
  logic       m_casc, m_hrq, m_gv;
  logic [2:0] m_gi;

  function automatic logic [3:0] model_win(input logic [3:0] pp, input logic [3:0] se,
                                           input logic [7:0] mk);
    logic [3:0] lp, ls;
    lp = pp & ~mk[3:0];
    ls = se & ~mk[7:4];
    for (int s = 0; s < 4; s++) begin
      if (ls[s]) begin
        if (s != 0) return {1'b1, 3'(4 + s)};
        for (int p = 0; p < 4; p++) if (lp[p]) return {1'b1, 3'(p)};
        return 4'd0;
      end
    end
    return 4'd0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pend <= '0; m_prev <= '0; m_casc <= 1'b0; m_hrq <= 1'b0;
      m_gv <= 1'b0; m_gi <= '0;
    end else begin : mdl
      logic [7:0] np;
      logic [3:0] se, w;
      logic kill, killp;
      kill  = tc && m_gv;
      killp = kill && !m_gi[2];
      se = {m_pend[7:5], m_casc};
      for (int c = 0; c < 8; c++) begin
        if (c == 4) np[c] = 1'b0;
        else if (swe && sch == 3'(c)) np[c] = sset;
        else if (req[c] && !m_prev[c]) np[c] = 1'b1;
        else if (!req[c] && m_prev[c]) np[c] = 1'b0;
        else np[c] = m_pend[c];
      end
      if (killp || m_pend[3:0] == 0) m_casc <= 1'b0;
      else if ((m_pend[3:0] & ~mask[3:0]) != 0) m_casc <= 1'b1;
      if (kill || se == 0) m_hrq <= 1'b0;
      else if ((se & ~mask[7:4]) != 0) m_hrq <= 1'b1;
      w = model_win(m_pend[3:0], se, mask);
      if (!kill && hlda && m_hrq && w[3]) begin
        m_gv <= 1'b1; m_gi <= w[2:0];
      end else begin
        m_gv <= 1'b0; m_gi <= '0;
      end
      m_pend <= np;
      m_prev <= req;
    end
  end

  function automatic logic [7:0] exp_dack(input logic gv, input logic [2:0] gi);
    if (!gv) return 8'h00;
    return (8'h01 << gi) | (gi[2] ? 8'h00 : 8'h10);
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R6 hold request vs model", 32'(hrq_o), 32'(m_hrq));
    chk("R7 grant valid vs model", 32'(grant_valid_o), 32'(m_gv));
    chk("R7 grant index vs model", 32'(grant_idx_o), 32'(m_gi));
    chk("R7 acknowledge vs model", 32'(dack_o), 32'(exp_dack(m_gv, m_gi)));
  endtask

  task automatic rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    req = '0; mask = '0; swe = 1'b0; sset = 1'b0; sch = '0; hlda = 1'b0; tc = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 reset hrq", 32'(hrq_o), 0);
    chk("R1 reset grant", 32'(grant_valid_o), 0);
    chk("R1 reset index", 32'(grant_idx_o), 0);
    chk("R1 reset dack", 32'(dack_o), 0);

    // R5/R6: primary request reaches hrq after two extra edges
    req = 8'h04;
    step(); chk("R5 latency 1", 32'(hrq_o), 0);
    step(); chk("R5 latency 2", 32'(hrq_o), 0);
    step(); chk("R6 hrq via cascade", 32'(hrq_o), 1);
    hlda = 1'b1;
    step(); chk("R7 primary grant idx", 32'(grant_idx_o), 2);
    chk("R7 primary dack with cascade", 32'(dack_o), 32'h14);
    req = 8'h46;
    step(); step();
    chk("R4 R11 re-evaluated priority", 32'(grant_idx_o), 1);
    chk("R4 dack", 32'(dack_o), 32'h12);
    mask = 8'h0F;
    step(); chk("R8 cascade wins, primary masked", 32'(grant_valid_o), 0);
    chk("R5 cascade held keeps hrq", 32'(hrq_o), 1);
    mask = 8'h1F;
    step(); chk("R4 secondary grant", 32'(grant_idx_o), 6);
    chk("R7 secondary dack", 32'(dack_o), 32'h40);
    tc = 1'b1;
    step(); chk("R10 tc drops grant", 32'(grant_valid_o), 0);
    chk("R10 tc drops hrq", 32'(hrq_o), 0);
    tc = 1'b0;
    step(); chk("R10 secondary hrq returns", 32'(hrq_o), 1);
    step(); chk("R7 secondary regrant", 32'(grant_idx_o), 6);
    mask = 8'h00; req = 8'h06;
    step(); step(); chk("R7 primary grant", 32'(grant_idx_o), 1);
    tc = 1'b1;
    step(); chk("R10 primary tc hrq", 32'(hrq_o), 0);
    tc = 1'b0;
    step(); chk("R10 cascade cleared", 32'(hrq_o), 0);
    step(); chk("R10 hrq after cascade", 32'(hrq_o), 1);
    // R9: reserved channel
    req = 8'h10;
    repeat (4) step();
    chk("R9 req on cascade slot", 32'(hrq_o), 0);
    chk("R9 no grant", 32'(grant_valid_o), 0);
    swe = 1'b1; sch = 3'd4; sset = 1'b1;
    step(); swe = 1'b0;
    step(); step();
    chk("R9 write to cascade slot", 32'(hrq_o), 0);
    // R3: request writes
    swe = 1'b1; sch = 3'd5; sset = 1'b1;
    step(); swe = 1'b0;
    step(); chk("R3 write sets pending", 32'(hrq_o), 1);
    step(); chk("R3 written channel granted", 32'(grant_idx_o), 5);
    chk("R3 dack", 32'(dack_o), 32'h20);
    swe = 1'b1; sch = 3'd5; sset = 1'b0;
    step(); swe = 1'b0;
    step(); chk("R3 write clears pending", 32'(hrq_o), 0);
    req = 8'h90; swe = 1'b1; sch = 3'd7; sset = 1'b0;
    step(); swe = 1'b0;
    step(); step();
    chk("R3 write beats request edge", 32'(hrq_o), 0);
    // R2: request edges
    req = 8'h10; step();
    req = 8'h90; step(); step();
    chk("R2 rising edge sets", 32'(hrq_o), 1);
    req = 8'h10; step(); step();
    chk("R2 falling edge clears", 32'(hrq_o), 0);

    // sweep of request patterns against related masks
    for (int r = 0; r < 256; r++) begin
      for (int k = 0; k < 4; k++) begin
        req  = 8'(r);
        mask = (k == 0) ? 8'h00 : (k == 1) ? 8'(r ^ 8'h5a) : (k == 2) ? ~8'(r) : 8'(r * 37);
        hlda = 1'b1;
        step(); step(); step();
      end
    end

    // pseudo-random run
    for (int i = 0; i < 20000; i++) begin
      rnd();
      if (lfsr[10:8] == 3'd0) req = lfsr[7:0];
      if (lfsr[13:11] == 3'd0) mask = lfsr[21:14] & lfsr[29:22];
      hlda = lfsr[30] | lfsr[31];
      tc   = (lfsr[3:0] == 4'd0);
      swe  = (lfsr[7:5] == 3'd0);
      sch  = lfsr[20:18];
      sset = lfsr[25];
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule